// File: doc/BRIEF.md
# Accumulator Shift-Round-Saturate Unit

This block converts data between wide accumulator lanes and narrow vector lanes, working on all lanes in parallel. In the down direction, each signed 48-bit accumulator lane is shifted right arithmetically by a programmable amount. The shifted value is rounded using the current rounding mode. It is then either clamped or wrapped into a 32-bit or 16-bit vector element. In the up direction, each vector element is sign-extended and shifted left into a 48-bit accumulator lane. No multiplication takes place on this path.

The rounding mode and the saturation enable are sticky. Each is changed by its own command, and each stays in force until another command changes it. With both cleared, a down-conversion is a plain arithmetic shift that keeps the low bits. The modes act only on the down-conversion; the upshift ignores them.

Inputs and results move through a valid/ready handshake. Each accepted operation produces one registered result in the next cycle.

Top module: `acc_srs_unit`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, the rounding mode is truncate (floor) and saturation is off.
- R2: With in_up = 0, every accumulator lane is shifted right arithmetically by in_shift, and a shift above 47 acts as 47. In rounding mode 0 the result is the floor of the shifted value.
- R3: In rounding mode 1 (half-up), one half of an output LSB is added before the floor is taken, so an exact tie rounds towards plus infinity.
- R4: In rounding mode 2 (half-to-even), a value that is not a tie rounds to the nearest integer, and an exact tie goes to the even neighbour.
- R5: With saturation on, a down result above or below the signed range of the selected width is clamped to that width's maximum or minimum. in_narrow = 0 selects 32 bits and in_narrow = 1 selects 16 bits. A 16-bit result sits in the low half of its 32-bit lane, sign-extended into the upper half.
- R6: With saturation off, a down result keeps only its low 32 or 16 bits, and a 16-bit result is sign-extended to 32 bits.
- R7: With in_up = 1, each vector lane is sign-extended and shifted left by in_shift (a shift above 47 acts as 47), keeping the low 48 bits. The lane source is all 32 bits when in_narrow = 0, and its low 16 bits when in_narrow = 1. Rounding and saturation modes have no effect. An upshift result has out_vec all zero, and a down result has out_acc all zero.
- R8: A command with cmd_vld = 1 is decoded from cmd_op:
  - 0 sets the rounding mode to cmd_rnd, where code 3 is stored as 0;
  - 1 clears the rounding mode to 0;
  - 2 turns saturation on;
  - 3 turns saturation off.
  A command applies to inputs accepted in later cycles, and the mode stays in force until the next command.
- R9: in_ready is high when out_valid is low or out_ready is high. A result appears one cycle after acceptance and holds steady while out_valid is high and out_ready is low.
- R10: Lane i occupies bits [48*i +: 48] of in_acc and out_acc, and bits [32*i +: 32] of in_vec and out_vec. Lanes do not interact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Mode command strobe |
| cmd_op | input | 2 | Command code: set rounding, clear rounding, saturation on, saturation off |
| cmd_rnd | input | 2 | Rounding mode applied by the set-rounding command |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Unit can accept an operation |
| in_up | input | 1 | 1 = upshift into the accumulator, 0 = down-conversion |
| in_narrow | input | 1 | 1 = 16-bit vector elements, 0 = 32-bit |
| in_shift | input | 6 | Shift amount |
| in_acc | input | 384 | Eight 48-bit accumulator lanes |
| in_vec | input | 256 | Eight 32-bit vector lanes |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_acc | output | 384 | Upshift result lanes |
| out_vec | output | 256 | Down-conversion result lanes |

## Verification
The bench targets exact ties of both signs under every rounding mode. A design that confuses half-up with half-away-from-zero, or that ignores the parity of the kept LSB, returns the wrong neighbour on the negative ties. It drives values just past both signed limits at each width, with saturation on and then off. This exposes clamps taken at the wrong width, and 16-bit results left without sign extension. It also sends shifts of 0, 47 and 63, an upshift whose result overflows while saturation is on, and a rounding command with code 3. Finally, a burst of random operations under random backpressure catches results that are dropped, repeated or changed while stalled.

// File: rtl/acc_srs_pkg.sv
package acc_srs_pkg;
  typedef enum logic [1:0] {
    RND_FLOOR     = 2'd0,
    RND_HALF_UP   = 2'd1,
    RND_HALF_EVEN = 2'd2
  } rnd_mode_e;

  typedef enum logic [1:0] {
    CMD_SET_RND = 2'd0,
    CMD_CLR_RND = 2'd1,
    CMD_SAT_ON  = 2'd2,
    CMD_SAT_OFF = 2'd3
  } srs_cmd_e;
endpackage

// File: rtl/srs_rst_sync.sv
module srs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/srs_mode_ctl.sv
module srs_mode_ctl
  import acc_srs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_vld,
  input  logic [1:0] cmd_op,
  input  logic [1:0] cmd_rnd,
  output rnd_mode_e rnd_mode,
  output logic      sat_en
);
  rnd_mode_e rnd_q, rnd_d;
  logic      sat_q, sat_d;

  // next-state: sticky modes, changed only by a command
  always_comb begin
    rnd_d = rnd_q;
    sat_d = sat_q;
    if (cmd_vld) begin
      unique case (srs_cmd_e'(cmd_op))
        CMD_SET_RND: rnd_d = (cmd_rnd == 2'd3) ? RND_FLOOR : rnd_mode_e'(cmd_rnd);
        CMD_CLR_RND: rnd_d = RND_FLOOR;
        CMD_SAT_ON:  sat_d = 1'b1;
        CMD_SAT_OFF: sat_d = 1'b0;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rnd_q <= RND_FLOOR;
      sat_q <= 1'b0;
    end else if (cmd_vld) begin
      rnd_q <= rnd_d;
      sat_q <= sat_d;
    end
  end

  assign rnd_mode = rnd_q;
  assign sat_en   = sat_q;
endmodule

// File: rtl/srs_lane_down.sv
module srs_lane_down
  import acc_srs_pkg::*;
#(
  parameter int ACC_W   = 48,
  parameter int VEC_W   = 32,
  parameter int NAR_W   = 16,
  parameter int SHIFT_W = 6
) (
  input  logic [ACC_W-1:0]   acc_lane,
  input  logic [SHIFT_W-1:0] shift_amt,
  input  rnd_mode_e          rnd_mode,
  input  logic               sat_en,
  input  logic               narrow,
  output logic [VEC_W-1:0]   vec_lane
);
  localparam int XW = ACC_W + 1;
  localparam logic signed [XW-1:0] WIDE_MAX = {{(XW-VEC_W+1){1'b0}}, {(VEC_W-1){1'b1}}};
  localparam logic signed [XW-1:0] WIDE_MIN = ~WIDE_MAX;
  localparam logic signed [XW-1:0] NAR_MAX  = {{(XW-NAR_W+1){1'b0}}, {(NAR_W-1){1'b1}}};
  localparam logic signed [XW-1:0] NAR_MIN  = ~NAR_MAX;

  logic signed [XW-1:0] ext;
  logic signed [XW-1:0] trunc;
  logic signed [XW-1:0] res;
  logic [ACC_W-1:0]     rem_mask;
  logic [ACC_W-1:0]     rem;
  logic [ACC_W-1:0]     half;
  logic                 rnd_up;
  logic                 over_w, under_w, over_n, under_n;
  logic [VEC_W-1:0]     wide_val;
  logic [NAR_W-1:0]     nar_val;

  // shift and the discarded fraction
  always_comb begin
    ext      = {acc_lane[ACC_W-1], acc_lane};
    trunc    = ext >>> shift_amt;
    rem_mask = ~({ACC_W{1'b1}} << shift_amt);
    rem      = acc_lane & rem_mask;
    half     = (shift_amt == '0) ? '0 : (ACC_W'(1) << (shift_amt - 1'b1));
  end

  // rounding decision
  always_comb begin
    rnd_up = 1'b0;
    if (shift_amt != '0) begin
      case (rnd_mode)
        RND_HALF_UP:   rnd_up = (rem >= half);
        RND_HALF_EVEN: rnd_up = (rem > half) || ((rem == half) && trunc[0]);
        default:       rnd_up = 1'b0;
      endcase
    end
    res = trunc + $signed({{(XW-1){1'b0}}, rnd_up});
  end

  // saturate or wrap to the selected width
  always_comb begin
    over_w  = sat_en && (res > WIDE_MAX);
    under_w = sat_en && (res < WIDE_MIN);
    over_n  = sat_en && (res > NAR_MAX);
    under_n = sat_en && (res < NAR_MIN);
    if (over_w)       wide_val = {1'b0, {(VEC_W-1){1'b1}}};
    else if (under_w) wide_val = {1'b1, {(VEC_W-1){1'b0}}};
    else              wide_val = res[VEC_W-1:0];
    if (over_n)       nar_val = {1'b0, {(NAR_W-1){1'b1}}};
    else if (under_n) nar_val = {1'b1, {(NAR_W-1){1'b0}}};
    else              nar_val = res[NAR_W-1:0];
    vec_lane = narrow ? {{(VEC_W-NAR_W){nar_val[NAR_W-1]}}, nar_val} : wide_val;
  end
endmodule

// File: rtl/srs_lane_up.sv
module srs_lane_up #(
  parameter int ACC_W   = 48,
  parameter int VEC_W   = 32,
  parameter int NAR_W   = 16,
  parameter int SHIFT_W = 6
) (
  input  logic [VEC_W-1:0]   vec_lane,
  input  logic [SHIFT_W-1:0] shift_amt,
  input  logic               narrow,
  output logic [ACC_W-1:0]   acc_lane
);
  logic [ACC_W-1:0] src;

  always_comb begin
    if (narrow) src = {{(ACC_W-NAR_W){vec_lane[NAR_W-1]}}, vec_lane[NAR_W-1:0]};
    else        src = {{(ACC_W-VEC_W){vec_lane[VEC_W-1]}}, vec_lane};
    acc_lane = src << shift_amt;
  end
endmodule

// File: rtl/acc_srs_unit.sv
module acc_srs_unit
  import acc_srs_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int ACC_W   = 48,
  parameter int VEC_W   = 32,
  parameter int NAR_W   = 16,
  parameter int SHIFT_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_vld,
  input  logic [1:0]             cmd_op,
  input  logic [1:0]             cmd_rnd,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_up,
  input  logic                   in_narrow,
  input  logic [SHIFT_W-1:0]     in_shift,
  input  logic [LANES*ACC_W-1:0] in_acc,
  input  logic [LANES*VEC_W-1:0] in_vec,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*ACC_W-1:0] out_acc,
  output logic [LANES*VEC_W-1:0] out_vec
);
  localparam int ACC_BUS   = LANES * ACC_W;
  localparam int VEC_BUS   = LANES * VEC_W;
  localparam int MAX_SHIFT = ACC_W - 1;

  logic             rst_sync_n;
  rnd_mode_e        rnd_q;
  logic             sat_q;
  logic [SHIFT_W-1:0] shift_eff;
  logic [ACC_BUS-1:0] up_acc;
  logic [VEC_BUS-1:0] dn_vec;
  logic             in_fire;
  logic             valid_d, valid_q;
  logic             up_d, up_q;
  logic [ACC_BUS-1:0] acc_d, acc_q;
  logic [VEC_BUS-1:0] vec_d, vec_q;

  srs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  srs_mode_ctl u_mode (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd_vld  (cmd_vld),
    .cmd_op   (cmd_op),
    .cmd_rnd  (cmd_rnd),
    .rnd_mode (rnd_q),
    .sat_en   (sat_q)
  );

  // one shared clamp of the shift amount for every lane
  always_comb begin
    shift_eff = (in_shift > SHIFT_W'(MAX_SHIFT)) ? SHIFT_W'(MAX_SHIFT) : in_shift;
  end

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    srs_lane_down #(
      .ACC_W(ACC_W), .VEC_W(VEC_W), .NAR_W(NAR_W), .SHIFT_W(SHIFT_W)
    ) u_down (
      .acc_lane  (in_acc[gi*ACC_W +: ACC_W]),
      .shift_amt (shift_eff),
      .rnd_mode  (rnd_q),
      .sat_en    (sat_q),
      .narrow    (in_narrow),
      .vec_lane  (dn_vec[gi*VEC_W +: VEC_W])
    );

    srs_lane_up #(
      .ACC_W(ACC_W), .VEC_W(VEC_W), .NAR_W(NAR_W), .SHIFT_W(SHIFT_W)
    ) u_up (
      .vec_lane  (in_vec[gi*VEC_W +: VEC_W]),
      .shift_amt (shift_eff),
      .narrow    (in_narrow),
      .acc_lane  (up_acc[gi*ACC_W +: ACC_W])
    );
  end

  // next-state of the output stage
  always_comb begin
    in_ready = !valid_q || out_ready;
    in_fire  = in_valid && in_ready;
    if (in_fire)        valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
    else                valid_d = valid_q;
    up_d  = in_up;
    acc_d = in_up ? up_acc : '0;
    vec_d = in_up ? '0 : dn_vec;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) valid_q <= 1'b0;
    else             valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      up_q  <= 1'b0;
      acc_q <= '0;
      vec_q <= '0;
    end else if (in_fire) begin
      up_q  <= up_d;
      acc_q <= acc_d;
      vec_q <= vec_d;
    end
  end

  assign out_valid = valid_q;
  assign out_acc   = acc_q;
  assign out_vec   = vec_q;
endmodule

// File: rtl/acc_srs_chk.sv
module acc_srs_chk
  import acc_srs_pkg::*;
#(
  parameter int ACC_BUS = 384,
  parameter int VEC_BUS = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [ACC_BUS-1:0] out_acc,
  input logic [VEC_BUS-1:0] out_vec,
  input logic               out_up,
  input logic               cmd_vld,
  input logic [1:0]         cmd_op,
  input rnd_mode_e          rnd_q,
  input logic               sat_q
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vec) && $stable(out_acc));

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !(in_valid && in_ready) |=> !out_valid);

  assert_up_vec_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_up |-> out_vec == '0);

  assert_down_acc_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_up |-> out_acc == '0);

  assert_clr_rnd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_op == CMD_CLR_RND |=> rnd_q == RND_FLOOR);

  assert_sat_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_op == CMD_SAT_ON |=> sat_q);

  assert_sat_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_op == CMD_SAT_OFF |=> !sat_q);
endmodule

bind acc_srs_unit acc_srs_chk #(
  .ACC_BUS (LANES*ACC_W),
  .VEC_BUS (LANES*VEC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_acc   (out_acc),
  .out_vec   (out_vec),
  .out_up    (up_q),
  .cmd_vld   (cmd_vld),
  .cmd_op    (cmd_op),
  .rnd_q     (rnd_q),
  .sat_q     (sat_q)
);

// File: tb/acc_srs_unit_test.sv
module acc_srs_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 50000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_vld;
  logic [1:0]   cmd_op;
  logic [1:0]   cmd_rnd;
  logic         in_valid;
  logic         in_ready;
  logic         in_up;
  logic         in_narrow;
  logic [5:0]   in_shift;
  logic [383:0] in_acc;
  logic [255:0] in_vec;
  logic         out_valid;
  logic         out_ready;
  logic [383:0] out_acc;
  logic [255:0] out_vec;

  typedef struct {
    logic [383:0] acc;
    logic [255:0] vec;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   cyc   = 0;
  bit   done  = 1'b0;
  bit   bp_en = 1'b0;
  int   mdl_rnd = 0;
  bit   mdl_sat = 1'b0;
  longint lv[8];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_srs_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_rnd(cmd_rnd),
    .in_valid(in_valid), .in_ready(in_ready), .in_up(in_up), .in_narrow(in_narrow),
    .in_shift(in_shift), .in_acc(in_acc), .in_vec(in_vec), .out_valid(out_valid),
    .out_ready(out_ready), .out_acc(out_acc), .out_vec(out_vec)
  );

  function automatic logic [31:0] mdl_down(longint a, int s, int rm, bit sat, bit nar);
    longint fl, rem, half, r, hi, lo;
    bit up;
    if (s > 47) s = 47;
    fl   = a >>> s;
    rem  = a - (fl <<< s);
    half = (s > 0) ? (64'sd1 <<< (s - 1)) : 64'sd0;
    up   = 1'b0;
    if (s > 0 && rm == 1) up = (rem >= half);
    if (s > 0 && rm == 2) up = (rem > half) || ((rem == half) && fl[0]);
    r = fl + (up ? 64'sd1 : 64'sd0);
    if (nar) begin hi = 64'sd32767; lo = -64'sd32768; end
    else begin hi = 64'sd2147483647; lo = -64'sd2147483648; end
    if (sat && r > hi) r = hi;
    if (sat && r < lo) r = lo;
    if (nar) return {{16{r[15]}}, r[15:0]};
    return r[31:0];
  endfunction

  function automatic logic [47:0] mdl_up(logic [31:0] v, int s, bit nar);
    longint src;
    longint r;
    if (s > 47) s = 47;
    src = nar ? longint'($signed(v[15:0])) : longint'($signed(v));
    r = src <<< s;
    return r[47:0];
  endfunction

  function automatic logic [383:0] pack_acc();
    logic [383:0] p;
    for (int i = 0; i < 8; i++) p[i*48 +: 48] = lv[i][47:0];
    return p;
  endfunction

  function automatic logic [255:0] pack_vec();
    logic [255:0] p;
    for (int i = 0; i < 8; i++) p[i*32 +: 32] = lv[i][31:0];
    return p;
  endfunction

  task automatic send(bit up, bit nar, int sh, logic [383:0] acc, logic [255:0] vec, string tag);
    exp_t e;
    for (int i = 0; i < 8; i++) begin
      if (up) begin
        e.acc[i*48 +: 48] = mdl_up(vec[i*32 +: 32], sh, nar);
        e.vec[i*32 +: 32] = '0;
      end else begin
        e.acc[i*48 +: 48] = '0;
        e.vec[i*32 +: 32] = mdl_down(longint'($signed(acc[i*48 +: 48])), sh, mdl_rnd, mdl_sat, nar);
      end
    end
    e.tag     = tag;
    in_valid  = 1'b1;
    in_up     = up;
    in_narrow = nar;
    in_shift  = 6'(sh);
    in_acc    = acc;
    in_vec    = vec;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    exp_q.push_back(e);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic cmd(int op, int code);
    cmd_vld = 1'b1;
    cmd_op  = 2'(op);
    cmd_rnd = 2'(code);
    @(posedge clk);
    #1;
    cmd_vld = 1'b0;
    case (op)
      0: mdl_rnd = (code == 3) ? 0 : code;
      1: mdl_rnd = 0;
      2: mdl_sat = 1'b1;
      default: mdl_sat = 1'b0;
    endcase
  endtask

  task automatic check_bit(bit act, bit exp, string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected result: acc %h vec %h expected none", out_acc, out_vec);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (out_acc !== e.acc || out_vec !== e.vec) begin
          n_bad++;
          $display("FAIL %s: got acc %h vec %h expected acc %h vec %h",
                   e.tag, out_acc, out_vec, e.acc, e.vec);
        end
      end
    end
  end

  // consumer backpressure
  always @(posedge clk) begin
    #1;
    out_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_vld = 1'b0; cmd_op = '0; cmd_rnd = '0;
    in_valid = 1'b0; in_up = 1'b0; in_narrow = 1'b0; in_shift = '0;
    in_acc = '0; in_vec = '0; out_ready = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    check_bit(out_valid, 1'b0, "R1 out_valid");
    check_bit(in_ready, 1'b1, "R1 in_ready");

    // R1 R2 R10: default floor, no saturation, distinct lanes
    lv = '{64'sd100, -64'sd100, 64'sd17, -64'sd17, 64'sd4096, -64'sd1, 64'sd15, -64'sd4097};
    send(0, 0, 4, pack_acc(), '0, "R1 default floor");
    lv = '{64'sd123456789, -64'sd98765, 64'sd1, -64'sd1, 64'sd70000, -64'sd70000, 64'sd0, 64'sd2};
    send(0, 0, 0, pack_acc(), '0, "R2 shift 0");
    lv = '{64'sh7FFFFFFFFFFF, -64'sh800000000000, 64'sd5, -64'sd5, 64'sh400000000000, -64'sd1, 64'sd1, 64'sd0};
    send(0, 0, 47, pack_acc(), '0, "R2 shift 47");
    send(0, 0, 63, pack_acc(), '0, "R2 shift 63 clamped");

    // ties: +-0.5, +-1.5, +-2.5 at shift 4, plus non-ties
    lv = '{64'sd8, -64'sd8, 64'sd24, -64'sd24, 64'sd40, -64'sd40, 64'sd9, -64'sd9};
    cmd(0, 1);
    send(0, 0, 4, pack_acc(), '0, "R3 half-up ties");
    cmd(0, 2);
    send(0, 0, 4, pack_acc(), '0, "R4 half-even ties");
    send(0, 1, 4, pack_acc(), '0, "R4 half-even narrow");
    cmd(0, 3);
    send(0, 0, 4, pack_acc(), '0, "R8 code 3 acts as floor");
    cmd(0, 1);
    cmd(1, 0);
    send(0, 0, 4, pack_acc(), '0, "R8 clear rounding");

    // saturation limits at both widths
    lv = '{64'sd2147483647, 64'sd2147483648, -64'sd2147483648, -64'sd2147483649,
           64'sd32767, 64'sd32768, -64'sd32768, -64'sd32769};
    cmd(2, 0);
    send(0, 0, 0, pack_acc(), '0, "R5 clamp 32");
    send(0, 1, 0, pack_acc(), '0, "R5 clamp 16");
    cmd(0, 1);
    send(0, 1, 1, pack_acc(), '0, "R5 clamp 16 with rounding");
    cmd(3, 0);
    send(0, 0, 0, pack_acc(), '0, "R6 wrap 32");
    send(0, 1, 0, pack_acc(), '0, "R6 wrap 16");
    send(0, 1, 1, pack_acc(), '0, "R8 rounding still sticky after sat off");
    cmd(1, 0);

    // upshift ignores modes, overflow wraps in 48 bits
    cmd(2, 0);
    cmd(0, 2);
    lv = '{64'sd1, -64'sd1, 64'sh7FFFFFFF, -64'sh80000000, 64'sh12345678, 64'sh8001, 64'sh7FFF, 64'sd0};
    send(1, 0, 20, '0, pack_vec(), "R7 upshift wide overflow");
    send(1, 1, 5, '0, pack_vec(), "R7 upshift narrow");
    send(1, 0, 63, '0, pack_vec(), "R7 upshift shift clamped");
    cmd(3, 0);
    cmd(1, 0);

    // R9 random burst under backpressure
    bp_en = 1'b1;
    for (int k = 0; k < 40; k++) begin
      logic [383:0] ra;
      logic [255:0] rv;
      for (int w = 0; w < 12; w++) ra[w*32 +: 32] = $urandom;
      for (int w = 0; w < 8; w++) rv[w*32 +: 32] = $urandom;
      if (k % 7 == 3) cmd($urandom % 4, $urandom % 4);
      send($urandom % 4 == 0, $urandom % 2, $urandom % 64, ra, rv, "R9 random burst");
    end
    bp_en = 1'b0;
    while (exp_q.size() != 0 || out_valid) @(posedge clk);
    #1;
    check_bit(exp_q.size() == 0, 1'b1, "R9 all results delivered");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule